// File: doc/BRIEF.md
# Ticket-Ordered Shared Lock Arbiter

This block guards one shared resource for a fixed set of agents and hands it out strictly in the order the requests arrived. An agent that wants the resource raises its acquire line for one cycle. The block gives it the current value of an issue counter as its ticket and then increments that counter. A second counter tracks how many holders have finished. An agent owns the resource while the finish counter equals its ticket. A grant line per agent reports ownership.

The holder gives the resource back by raising its release line for one cycle. The finish counter then moves forward by one, and the next ticket in line is granted. Requests that arrive in the same cycle are placed in ascending agent-index order. Both counters wrap, and they are compared only on their wrapped values. A release that the block cannot honour is dropped and reported with a one-cycle error pulse.

Top module: `ticket_lock`

## Requirements
- R1: While reset is low and in the first cycle after it, every grant bit and the error output are 0. The first ticket issued after reset is 0.
- R2: An acquire from an agent that holds no ticket is accepted. That agent's ticket field on `ticketOut` (bits `i*TW +: TW`) shows the issue counter value from before the increment, starting the cycle after the request. The issue counter rises by one for each accepted acquire.
- R3: When several agents acquire in the same cycle, they receive consecutive tickets, and a lower agent index gets the lower ticket.
- R4: `grant[i]` is a registered output. It goes high one cycle after the finish counter equals agent i's ticket. At most one grant bit is high at any time.
- R5: A release from the granted agent moves the finish counter forward by one. The agent's grant drops at the next edge, and no grant is high in the cycle that follows.
- R6: The resource is granted in strict ticket order. A holder keeps its grant until it releases.
- R7: Tickets and both counters are `TW = clog2(NUM_AGENTS+1) + EXTRA_BITS` bits wide and wrap modulo 2^TW. With 4 agents and no extra bits, the tickets run 0..7 and then return to 0.
- R8: A release is ignored when no ticket is outstanding or when the agent is not the current holder. In that case `relErr` is high for exactly the one cycle after it.
- R9: An acquire from an agent that is already waiting or holding is ignored. Its ticket is kept and the issue counter does not move.
- R10: An acquire by one agent and a release by the holder in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acqReq | input | NUM_AGENTS | One-cycle acquire request per agent |
| relReq | input | NUM_AGENTS | One-cycle release request per agent |
| ticketOut | output | NUM_AGENTS*TW | Ticket held by each agent, agent i at bits i*TW +: TW |
| grant | output | NUM_AGENTS | Registered ownership flag per agent |
| relErr | output | 1 | One-cycle pulse after a rejected release |

## Verification
Ticket issue and release can fall in the same cycle. Both also interact with the registered grant compare. The bench forces this overlap twice: once while the lock is busy, and once when the new request comes from the agent just served. It checks that the new ticket reflects only the issue counter and that the next grant arrives exactly one cycle after the finish counter moves. All four agents also request together across the wrap point of the counters. The bench judges that burst by the tickets each agent receives and by the order in which the grants appear.

// File: rtl/lock_pkg.sv
package lock_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // finish counter steps by one
    logic flagErr;   // a release was rejected this cycle
  } lockStrobes_t;
endpackage

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
#(
  parameter int NUM_AGENTS = 4
) (
  input  logic [NUM_AGENTS-1:0] acqReq,
  input  logic [NUM_AGENTS-1:0] relReq,
  input  logic [NUM_AGENTS-1:0] pending,
  input  logic [NUM_AGENTS-1:0] grant,
  output logic [NUM_AGENTS-1:0] issueMask,
  output logic [NUM_AGENTS-1:0] releaseMask,
  output lockStrobes_t          strb
);
  logic [NUM_AGENTS-1:0] badRel;

  always_comb begin
    // only idle agents may draw a ticket
    issueMask   = acqReq & ~pending;
    // only the current holder may give the lock back
    releaseMask = relReq & grant;
    badRel      = relReq & ~grant;
    strb.advance = |releaseMask;
    strb.flagErr = |badRel;
  end
endmodule

// File: rtl/lock_dp.sv
module lock_dp
  import lock_pkg::*;
#(
  parameter int NUM_AGENTS = 4,
  parameter int TW         = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lockStrobes_t             strb,
  input  logic [NUM_AGENTS-1:0]    issueMask,
  input  logic [NUM_AGENTS-1:0]    releaseMask,
  output logic [NUM_AGENTS-1:0]    pending,
  output logic [NUM_AGENTS-1:0]    grant,
  output logic [NUM_AGENTS*TW-1:0] ticketOut,
  output logic                     relErr
);
  logic [TW-1:0] nextTicket;
  logic [TW-1:0] nowServing;
  logic [TW-1:0] offs [NUM_AGENTS];
  logic [TW-1:0] issueCount;

  // prefix count: lower index draws the lower ticket
  always_comb begin
    issueCount = '0;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      offs[i]    = issueCount;
      issueCount = issueCount + TW'(issueMask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextTicket <= '0;
      nowServing <= '0;
      relErr     <= 1'b0;
    end else begin
      nextTicket <= nextTicket + issueCount;
      if (strb.advance) nowServing <= nowServing + TW'(1);
      relErr <= strb.flagErr;
    end
  end

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : gAgent
    logic [TW-1:0] myTicket;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pending[g] <= 1'b0;
        grant[g]   <= 1'b0;
        myTicket   <= '0;
      end else begin
        if (issueMask[g]) begin
          pending[g] <= 1'b1;
          myTicket   <= nextTicket + offs[g];
        end else if (releaseMask[g]) begin
          pending[g] <= 1'b0;
        end
        grant[g] <= pending[g] && (myTicket == nowServing) && !releaseMask[g];
      end
    end
    assign ticketOut[g*TW +: TW] = myTicket;
  end
endmodule

// File: rtl/ticket_lock.sv
module ticket_lock
  import lock_pkg::*;
#(
  parameter int NUM_AGENTS = 4,
  parameter int EXTRA_BITS = 0,
  localparam int TW = $clog2(NUM_AGENTS + 1) + EXTRA_BITS
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_AGENTS-1:0]    acqReq,
  input  logic [NUM_AGENTS-1:0]    relReq,
  output logic [NUM_AGENTS*TW-1:0] ticketOut,
  output logic [NUM_AGENTS-1:0]    grant,
  output logic                     relErr
);
  lockStrobes_t          strb;
  logic [NUM_AGENTS-1:0] issueMask;
  logic [NUM_AGENTS-1:0] releaseMask;
  logic [NUM_AGENTS-1:0] pending;

  lock_ctrl #(.NUM_AGENTS(NUM_AGENTS)) u_ctrl (
    .acqReq(acqReq), .relReq(relReq), .pending(pending), .grant(grant),
    .issueMask(issueMask), .releaseMask(releaseMask), .strb(strb)
  );

  lock_dp #(.NUM_AGENTS(NUM_AGENTS), .TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .issueMask(issueMask),
    .releaseMask(releaseMask), .pending(pending), .grant(grant),
    .ticketOut(ticketOut), .relErr(relErr)
  );
endmodule

// File: rtl/lock_chk.sv
module lock_chk #(
  parameter int NUM_AGENTS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_AGENTS-1:0] acqReq,
  input logic [NUM_AGENTS-1:0] relReq,
  input logic [NUM_AGENTS-1:0] grant,
  input logic                  relErr
);
  logic rstPrev;
  logic started;
  always_ff @(posedge clk) begin
    rstPrev <= rstN;
    started <= 1'b1;
    // R1
    if (started && !rstPrev) begin
      reset_clear_chk: assert (grant == '0 && !relErr);
    end
  end

  // R4
  single_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R8
  bad_release_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(relReq & ~grant)) |=> relErr);

  // R8
  no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|(relReq & ~grant)) |=> !relErr);

  // R5
  release_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(relReq & grant)) |=> (grant == '0));

  // R6
  holder_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((grant != '0) && !(|(relReq & grant))) |=> (grant == $past(grant)));

  // R9
  reacquire_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|(acqReq & grant)) && !(|(relReq & grant))) |=> $stable(grant));
endmodule

bind ticket_lock lock_chk #(.NUM_AGENTS(NUM_AGENTS)) u_lock_chk (
  .clk(clk), .rstN(rstN), .acqReq(acqReq), .relReq(relReq),
  .grant(grant), .relErr(relErr)
);

// File: tb/test_ticket_lock.sv
module test_ticket_lock;
  localparam int N  = 4;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  acqReq = '0;
  logic [N-1:0]  relReq = '0;
  logic [N*TW-1:0] ticketOut;
  logic [N-1:0]  grant;
  logic          relErr;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ticket_lock #(.NUM_AGENTS(N), .EXTRA_BITS(0)) i_ticket_lock (
    .clk(clk), .rstN(rstN), .acqReq(acqReq), .relReq(relReq),
    .ticketOut(ticketOut), .grant(grant), .relErr(relErr)
  );

  // {acq, rel, expected grant, expected err} ; R2 R4 R5 R6 R8 R10
  localparam logic [12:0] VEC [15] = '{
    {4'b0101, 4'b0000, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0001, 1'b0},
    {4'b1010, 4'b0000, 4'b0001, 1'b0},
    {4'b0000, 4'b0001, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0100, 1'b0},
    {4'b0000, 4'b0010, 4'b0100, 1'b1},
    {4'b0001, 4'b0100, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0010, 1'b0},
    {4'b0000, 4'b0010, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b1000, 1'b0},
    {4'b0000, 4'b1000, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0001, 1'b0},
    {4'b0000, 4'b0001, 4'b0000, 1'b0},
    {4'b0000, 4'b0001, 4'b0000, 1'b1},
    {4'b0000, 4'b0000, 4'b0000, 1'b0}
  };

  function automatic logic [TW-1:0] tk(int a);
    return ticketOut[a*TW +: TW];
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(logic [N-1:0] a, logic [N-1:0] r);
    acqReq = a;
    relReq = r;
    @(negedge clk);
    acqReq = '0;
    relReq = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", grant, 0);
    chk("R1 err in reset", relErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 grant after reset", grant, 0);

    for (int v = 0; v < 15; v++) begin
      cyc(VEC[v][12:9], VEC[v][8:5]);
      chk($sformatf("R4/R5/R8 vec%0d grant", v), grant, VEC[v][4:1]);
      chk($sformatf("R8 vec%0d err", v), relErr, VEC[v][0]);
      if (v == 0) begin
        chk("R1 first ticket", tk(0), 0);
        chk("R3 second same-cycle ticket", tk(2), 1);
      end
      if (v == 2) begin
        chk("R3 agent1 ticket", tk(1), 2);
        chk("R3 agent3 ticket", tk(3), 3);
      end
      if (v == 6) chk("R10 ticket during release", tk(0), 4);
    end

    // wrap: serving = issue = 5
    for (int k = 0; k < 10; k++) begin
      cyc(4'b0001, 4'b0000);
      chk("R7 wrapped ticket", tk(0), (5 + k) % 8);
      cyc(4'b0000, 4'b0000);
      chk("R7 grant after wrap", grant, 1);
      cyc(4'b0000, 4'b0001);
      chk("R5 drop", grant, 0);
    end

    // all four at once across the wrap point: base 7
    cyc(4'b1111, 4'b0000);
    chk("R3 a0", tk(0), 7);
    chk("R3 a1", tk(1), 0);
    chk("R3 a2", tk(2), 1);
    chk("R3 a3", tk(3), 2);
    cyc(4'b0010, 4'b0000);
    chk("R9 ticket kept", tk(1), 0);
    chk("R6 first grant", grant, 4'b0001);
    cyc(4'b0000, 4'b0001);
    cyc(4'b0000, 4'b0000);
    chk("R6 second grant", grant, 4'b0010);
    cyc(4'b0000, 4'b0010);
    cyc(4'b0000, 4'b0000);
    chk("R6 third grant", grant, 4'b0100);
    cyc(4'b0000, 4'b0100);
    cyc(4'b0000, 4'b0000);
    chk("R6 fourth grant", grant, 4'b1000);
    cyc(4'b0001, 4'b1000);
    chk("R9 issue counter unmoved", tk(0), 3);
    chk("R10 grant cleared", grant, 0);
    cyc(4'b0000, 4'b0000);
    chk("R10 new holder", grant, 4'b0001);

    // reset in mid-run
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 grant cleared", grant, 0);
    chk("R1 err cleared", relErr, 0);
    rstN = 1'b1;
    cyc(4'b0100, 4'b0000);
    chk("R1 ticket restarts", tk(2), 0);
    cyc(4'b0000, 4'b0000);
    chk("R1 grant after restart", grant, 4'b0100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule